// File: doc/BRIEF.md
# Bit-Level Serial EEPROM Responder

This block models a small read-only serial EEPROM as seen from a bit-banged two-wire master. The master samples its clock and data lines and hands the block one sampled pair per step, marked by a strobe. For every step the block returns the data level the master reads back. That level is either the master's own data level or a value the block forces.

A frame opens with a start condition. The block then takes a command byte and answers with an acknowledge. Next it takes an address byte. On a read, during that address byte it shifts out the byte it latched at the end of the previous frame. When the address byte is complete, it latches the addressed memory byte and sends a second acknowledge. It then returns to idle. The memory is a 256-byte constant table. There is no write path, no clock stretching and no multi-byte burst.

Top module: `eep_bit_responder`

## Requirements
- R1: After reset the returned level `sda_out` is 1 and the block is idle: no frame is open and no acknowledge is pending.
- R2: A start is a strobed step where SCL is high in both the previous and the current step and SDA falls from 1 to 0. A start opens a new command phase and discards any partly received frame.
- R3: A stop is a strobed step where SCL is high in both steps and SDA rises from 0 to 1. A stop changes no frame state, so a frame interrupted by a stop continues with its next bit.
- R4: While idle, every step other than a start leaves the frame state unchanged, and `sda_out` simply follows `sda_in`.
- R5: A bit is taken only on an SCL rising step (0 then 1) in which SDA holds the value of the previous step. A rising step in which SDA changes is ignored and consumes no bit.
- R6: When an acknowledge is pending, the next SCL rising step returns `sda_out` = 0 and clears the pending flag without consuming a bit.
- R7: The command phase takes 8 bits, first bit as the most significant. After the 8th bit an acknowledge is pending. Command bit 0 = 1 selects a read.
- R8: The address phase takes 8 bits, most significant first. On a read, each accepted address bit returns the most significant bit of the held data byte on `sda_out`, and the byte then shifts left by one.
- R9: After the 8th address bit the block latches the memory byte at the received address, sets an acknowledge pending and returns to idle. The next read frame shifts out this byte.
- R10: Memory bytes 0x00..0x07 hold 80 08 04 0D 0A 01 40 00. Bytes 0x3E and 0x3F hold 12 and D0. Bytes 0x7E and 0x7F hold 64 and F4. All other bytes hold 00.
- R11: `sda_out` is the last stored data level. That is the strobed `sda_in`, unless the block forced an acknowledge 0 or a read data bit in that step.
- R12: A step with `smp_valid` low changes neither the state nor `sda_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Strobe: the SCL/SDA pair on this cycle is one step |
| scl_in | input | 1 | Sampled clock line level |
| sda_in | input | 1 | Sampled data line level driven by the master |
| sda_out | output | 1 | Data level the master reads back |

## Verification
Every result of a strobed step is registered once. So `sda_out` and all frame state change on the clock edge that accepts the strobe, and none of them change later. The bench drives a step on the falling edge and holds the strobe through one rising edge. It reads `sda_out` one time unit after that rising edge, so each check sees exactly the step it just drove. Read data always lags by one frame, so the expected byte for a read is the model value at the address given in the previous frame.

// File: rtl/eep_pkg.sv
// Package: shared types and the constant memory image for the serial EEPROM responder.
// Assumes an 8-bit memory word; unlisted addresses read as zero.
package eep_pkg;

    // Line events decoded from one step against the previous step.
    typedef struct packed {
        logic start;   // SCL high twice, SDA 1 -> 0
        logic stop;    // SCL high twice, SDA 0 -> 1
        logic rise;    // SCL 0 -> 1
        logic steady;  // SDA equal to the previous step
    } line_ev_t;

    // Constant memory image, computed per address.
    function automatic logic [7:0] init_byte(input int idx);
        logic [7:0] v;
        case (idx)
            'h00: v = 8'h80;
            'h01: v = 8'h08;
            'h02: v = 8'h04;
            'h03: v = 8'h0D;
            'h04: v = 8'h0A;
            'h05: v = 8'h01;
            'h06: v = 8'h40;
            'h3E: v = 8'h12;
            'h3F: v = 8'hD0;
            'h7E: v = 8'h64;
            'h7F: v = 8'hF4;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/eep_line_monitor.sv
// Module: eep_line_monitor
// Decodes start, stop, rising-clock and data-stability events from the
// previous stored line levels and the current sample. Purely combinational;
// assumes the caller only acts on the result when the sample strobe is high.
module eep_line_monitor
    import eep_pkg::*;
(
    input  logic     prev_scl,
    input  logic     prev_sda,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);

    logic both_high;
    logic sda_moved;

    // Event decode for one step.
    always_comb begin
        both_high = prev_scl & scl_in;
        sda_moved = prev_sda ^ sda_in;
        ev.start  = both_high & sda_moved & ~sda_in;
        ev.stop   = both_high & sda_moved &  sda_in;
        ev.rise   = ~prev_scl & scl_in;
        ev.steady = ~sda_moved;
    end

endmodule

// File: rtl/eep_rom.sv
// Module: eep_rom
// Constant memory of 2**ADDR_W words, built from the package image function.
// Asynchronous read; assumes DATA_W <= 8 (upper image bits are dropped).
module eep_rom
    import eep_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] image [DEPTH];

    // One constant word per address.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam logic [7:0] WORD = init_byte(g);
        assign image[g] = WORD[DATA_W-1:0];
    end

    // Asynchronous lookup.
    always_comb rd_data = image[rd_addr];

endmodule

// File: rtl/eep_bit_engine.sv
// Module: eep_bit_engine
// Frame sequencer. One tick counter spans the command phase (ticks 1..CMD_W)
// and the address phase (ticks CMD_W+1..CMD_W+ADDR_W); tick 0 is idle.
// Acknowledges are inserted on the rising step after the pending flag is set.
// Assumes line events come from eep_line_monitor fed with prev_scl/prev_sda.
module eep_bit_engine
    import eep_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              scl_in,
    input  logic              sda_in,
    input  line_ev_t          ev,
    output logic              prev_scl,
    output logic              prev_sda,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_data
);

    localparam int CMD_END  = CMD_W + 1;
    localparam int ADDR_END = CMD_END + ADDR_W;
    localparam int TICK_W   = $clog2(ADDR_END + 1);
    localparam logic [TICK_W-1:0] T_IDLE  = '0;
    localparam logic [TICK_W-1:0] T_FIRST = TICK_W'(1);
    localparam logic [TICK_W-1:0] T_CEND  = TICK_W'(CMD_END);
    localparam logic [TICK_W-1:0] T_AEND  = TICK_W'(ADDR_END);

    logic [TICK_W-1:0] tick_q, tick_n;
    logic              ack_q, ack_n;
    logic [CMD_W-1:0]  cmd_q, cmd_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [DATA_W-1:0] data_q, data_n;
    logic              scl_q, scl_n;
    logic              sda_q, sda_n;
    logic [TICK_W-1:0] tick_inc;
    logic              is_read;

    assign tick_inc = tick_q + TICK_W'(1);
    assign is_read  = cmd_q[0];
    assign rom_addr = {addr_q[ADDR_W-2:0], sda_in};
    assign prev_scl = scl_q;
    assign prev_sda = sda_q;

    // Next-state decode for one strobed step.
    always_comb begin
        tick_n = tick_q;
        ack_n  = ack_q;
        cmd_n  = cmd_q;
        addr_n = addr_q;
        data_n = data_q;
        scl_n  = scl_q;
        sda_n  = sda_q;
        if (smp_valid) begin
            scl_n = scl_in;
            sda_n = sda_in;
            if (ev.start) begin
                tick_n = T_FIRST;
                cmd_n  = '0;
            end else if (ev.stop) begin
                // stop: state kept as is
            end else if (tick_q == T_IDLE && !ack_q) begin
                // idle: wait for a start
            end else if (ev.rise) begin
                if (ack_q) begin
                    sda_n = 1'b0;
                    ack_n = 1'b0;
                end else if (ev.steady) begin
                    if (tick_q < T_CEND) begin
                        cmd_n  = {cmd_q[CMD_W-2:0], sda_in};
                        tick_n = tick_inc;
                        if (tick_inc == T_CEND) ack_n = 1'b1;
                    end else if (tick_q < T_AEND) begin
                        if (is_read) sda_n = data_q[DATA_W-1];
                        addr_n = rom_addr;
                        data_n = data_q << 1;
                        tick_n = tick_inc;
                        if (tick_inc == T_AEND) begin
                            data_n = rom_data;
                            ack_n  = 1'b1;
                            tick_n = T_IDLE;
                        end
                    end else begin
                        sda_n = 1'b0;
                    end
                end
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= T_IDLE;
            ack_q  <= 1'b0;
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            tick_q <= tick_n;
            ack_q  <= ack_n;
            cmd_q  <= cmd_n;
            addr_q <= addr_n;
            data_q <= data_n;
            scl_q  <= scl_n;
            sda_q  <= sda_n;
        end
    end

    // Counter never rests on the final address tick.
    assert_tick_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q < T_AEND);

    assert_start_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && ev.start |=> tick_q == T_FIRST && cmd_q == '0);

    assert_stop_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && ev.stop |=> $stable(tick_q) && $stable(ack_q) && $stable(addr_q) && $stable(data_q));

    assert_idle_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && tick_q == T_IDLE && !ack_q && !ev.start |=> tick_q == T_IDLE && !ack_q && $stable(addr_q));

    assert_glitch_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && ev.rise && !ev.steady && !ack_q |=> $stable(tick_q) && $stable(cmd_q) && $stable(addr_q));

    assert_ack_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && ack_q && ev.rise |=> !ack_q && !sda_q && $stable(tick_q));

    assert_cmd_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q && tick_q != T_IDLE |-> tick_q == T_CEND);

    assert_read_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && ev.rise && ev.steady && !ack_q && tick_q >= T_CEND && is_read
        |=> sda_q == $past(data_q[DATA_W-1]));

    assert_load_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && ev.rise && ev.steady && !ack_q && tick_inc == T_AEND |=> tick_q == T_IDLE && ack_q);

    assert_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !ev.rise |=> sda_q == $past(sda_in) && scl_q == $past(scl_in));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(tick_q) && $stable(sda_q) && $stable(scl_q) && $stable(ack_q));

endmodule

// File: rtl/eep_bit_responder.sv
// Module: eep_bit_responder (top)
// Bit-level responder modelling a read-only serial EEPROM. Each strobed
// SCL/SDA pair is one step; sda_out is the level the master reads back.
// Assumes the master supplies already-sampled line levels.
module eep_bit_responder
    import eep_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_out
);

    line_ev_t          ev;
    logic              prev_scl;
    logic              prev_sda;
    logic [ADDR_W-1:0] rom_addr;
    logic [DATA_W-1:0] rom_data;

    eep_line_monitor u_mon (
        .prev_scl (prev_scl),
        .prev_sda (prev_sda),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .ev       (ev)
    );

    eep_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
        .rd_addr (rom_addr),
        .rd_data (rom_data)
    );

    eep_bit_engine #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .ev        (ev),
        .prev_scl  (prev_scl),
        .prev_sda  (prev_sda),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data)
    );

    // Returned level is the stored data level.
    assign sda_out = prev_sda;

endmodule

// File: tb/eep_bit_responder_bench.sv
// Bench: table of frames walked by one loop, then directed corner cases.
module eep_bit_responder_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic sda_out;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] held = 8'h00;

    always #5 clk = ~clk;

    eep_bit_responder u_eep_bit_responder (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .scl_in(scl_in), .sda_in(sda_in), .sda_out(sda_out)
    );

    // Frame table: {command, address}
    localparam int NTX = 11;
    localparam logic [15:0] FRAMES [NTX] = '{
        {8'hA0, 8'h3E}, {8'hA1, 8'h7E}, {8'hA1, 8'h00}, {8'hA1, 8'h06},
        {8'hA1, 8'h3F}, {8'hA1, 8'h7F}, {8'hA1, 8'h10}, {8'hA1, 8'h03},
        {8'hA1, 8'hFF}, {8'hA0, 8'h01}, {8'hA1, 8'h02}
    };

    // Independent memory model from R10.
    function automatic logic [7:0] model_byte(input logic [7:0] a);
        case (a)
            8'h00: return 8'h80; 8'h01: return 8'h08; 8'h02: return 8'h04;
            8'h03: return 8'h0D; 8'h04: return 8'h0A; 8'h05: return 8'h01;
            8'h06: return 8'h40; 8'h3E: return 8'h12; 8'h3F: return 8'hD0;
            8'h7E: return 8'h64; 8'h7F: return 8'hF4;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic c, input logic d);
        @(negedge clk);
        scl_in = c; sda_in = d; smp_valid = 1'b1;
        @(posedge clk); #1;
        smp_valid = 1'b0;
    endtask

    // Full frame; glitch_at < 8 inserts a changing-SDA rise before that
    // command bit, stop_mid inserts a stop after the first address bit.
    task automatic run_frame(input logic [7:0] cmd, input logic [7:0] addr,
                             input logic [7:0] exp_rd, input int glitch_at,
                             input bit stop_mid);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 7; i >= 0; i--) begin
            if (7 - i == glitch_at) begin
                step(1'b0, 1'b0);
                step(1'b1, 1'b1);
                chk(sda_out, 1'b1, "R5 glitch rise passes level");
            end
            step(1'b0, cmd[i]);
            step(1'b1, cmd[i]);
            chk(sda_out, cmd[i], "R7 command bit echoed (R11)");
        end
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        chk(sda_out, 1'b0, "R6 command acknowledge");
        for (int i = 7; i >= 0; i--) begin
            step(1'b0, addr[i]);
            step(1'b1, addr[i]);
            chk(sda_out, cmd[0] ? exp_rd[i] : addr[i], "R8 address phase level");
            if (stop_mid && i == 7) begin
                step(1'b1, 1'b1);
                chk(sda_out, 1'b1, "R3 stop mid frame");
            end
        end
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        chk(sda_out, 1'b0, "R9 acknowledge after address");
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk(sda_out, 1'b1, "R11 level after stop");
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        chk(sda_out, 1'b1, "R1 reset level");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(sda_out, 1'b1, "R1 level after reset release");

        // R4: idle steps are ignored, level follows input
        step(1'b0, 1'b0);
        chk(sda_out, 1'b0, "R4 idle follows low");
        step(1'b1, 1'b0);
        chk(sda_out, 1'b0, "R4 idle rise ignored");
        step(1'b1, 1'b1);
        chk(sda_out, 1'b1, "R4 idle stop follows");

        // R12: pins move without strobe
        @(negedge clk);
        scl_in = 1'b0; sda_in = 1'b0;
        @(posedge clk); #1;
        chk(sda_out, 1'b1, "R12 no strobe no change");
        scl_in = 1'b1; sda_in = 1'b1;

        // Table walk (R7, R8, R9, R10)
        for (int k = 0; k < NTX; k++) begin
            run_frame(FRAMES[k][15:8], FRAMES[k][7:0], held, 8, 1'b0);
            held = model_byte(FRAMES[k][7:0]);
        end

        // R3: stop inside address phase of a write frame
        run_frame(8'hA0, 8'h3E, held, 8, 1'b1);
        held = model_byte(8'h3E);
        run_frame(8'hA1, 8'h7F, held, 8, 1'b0);
        held = model_byte(8'h7F);
        chk(held == 8'hF4, 1'b1, "R10 model sanity");

        // R5: changing-SDA rise inside the command phase
        run_frame(8'hA1, 8'h3F, held, 3, 1'b0);
        held = model_byte(8'h3F);

        // R2: partial frame aborted by a new start
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1); step(1'b1, 1'b1);
        step(1'b0, 1'b0); step(1'b1, 1'b0);
        step(1'b0, 1'b1); step(1'b1, 1'b1);
        chk(sda_out, 1'b1, "R2 partial frame bit");
        run_frame(8'hA1, 8'h00, held, 8, 1'b0);
        held = model_byte(8'h00);
        run_frame(8'hA1, 8'h05, held, 8, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule